// File: doc/BRIEF.md
# Lane-Mask Warp Sync Barrier

This unit synchronises the lanes of one warp at a barrier whose participants are picked per call. A lane presents a sync request together with a lane mask: bit i of the mask stands for lane i, and only lanes whose bit is set take part. The unit holds arriving lanes until every lane named in the mask has presented a request carrying the identical mask value. It then releases that whole group with a single-cycle pulse on exactly those lanes, and their arrival state clears so the group can meet again at once.

The unit screens every request. A request whose mask leaves out the requesting lane's own bit is illegal. A request whose mask overlaps a different mask, either one already waiting or one arriving in the same cycle, is a conflict. Both cases raise a one-cycle error pulse, and the offending requests are dropped without changing any waiting group. Groups whose masks are disjoint run independently of each other. The warp width is a parameter.

Top module: `wsb_warp_barrier`

## Requirements
- R1: After reset, `lane_go` is all zeros and `mask_err` is low, and both stay low while no request is presented.
- R2: Lane i's mask is the field `sync_mask[i*LANES +: LANES]`, and bit j of that field names lane j as a participant.
- R3: When the last lane of a mask arrives in cycle k, `lane_go` equals exactly that mask in cycle k+1. No bit of the group rises earlier.
- R4: A release lasts one cycle and clears the released lanes' arrivals, so a later request from one of those lanes waits again for the whole mask.
- R5: A request whose mask has its own lane's bit clear raises `mask_err` in the next cycle. The request is discarded and the lane is not recorded as waiting.
- R6: A request whose mask overlaps, but differs from, the mask of a lane already waiting raises `mask_err` in the next cycle. The newcomer is discarded and the waiting group is unaffected.
- R7: Two requests in the same cycle whose masks overlap but differ both raise `mask_err` in the next cycle, and both are discarded.
- R8: Groups with disjoint masks gather and release independently, in any interleaving.
- R9: A request from a lane that is already waiting is ignored. It raises no error and leaves the lane's recorded mask unchanged.
- R10: A lane whose mask names only itself is released alone in the next cycle.
- R11: When all lanes request the all-ones mask in the same cycle, every lane is released together in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | LANES | Per-lane sync request, sampled every cycle |
| sync_mask | input | LANES*LANES | Per-lane participant masks, lane i in bits i*LANES upward |
| lane_go | output | LANES | Per-lane release pulse |
| mask_err | output | 1 | One-cycle pulse on an illegal or conflicting request |

## Verification
A lost or stale arrival bit shows at the ports in one of three ways. A group stays silent after its last member arrives, or it fires one member short, or an innocent later request with the same mask raises `mask_err`, because the stale entry then looks like a clashing waiter. A wrong recorded mask releases a group larger or smaller than its mask. All of these appear in the cycle after the request that should have completed or been screened. The scenarios therefore test discarded requests by sending a follow-up request that would complete a group or clash only if the discarded request had been kept.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
   // Legal range of the warp width parameter.
   localparam int unsigned WSB_MIN_LANES = 2;
   localparam int unsigned WSB_MAX_LANES = 64;
endpackage

// File: rtl/wsb_screen.sv
// Request screening: own-bit legality and mask-agreement against waiting
// lanes and same-cycle peers.
module wsb_screen #(
   parameter int unsigned LANES = 32
) (
   input  logic [LANES-1:0]            req,
   input  logic [LANES-1:0][LANES-1:0] want,
   input  logic [LANES-1:0]            waiting,
   input  logic [LANES-1:0][LANES-1:0] held,
   output logic [LANES-1:0]            take,
   output logic                        fault
);
   logic [LANES-1:0]            fresh;
   logic [LANES-1:0]            self_ok;
   logic [LANES-1:0]            clash;
   logic [LANES-1:0][LANES-1:0] hit;

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      assign fresh[gi]   = req[gi] & ~waiting[gi];
      assign self_ok[gi] = want[gi][gi];
      for (genvar gj = 0; gj < LANES; gj++) begin : g_peer
         if (gj == gi) begin : g_self
            assign hit[gi][gj] = 1'b0;
         end else begin : g_other
            logic pend_bad;
            logic peer_bad;
            assign pend_bad = waiting[gj] & (|(held[gj] & want[gi]))
                              & (held[gj] != want[gi]);
            assign peer_bad = fresh[gj] & self_ok[gj] & (|(want[gj] & want[gi]))
                              & (want[gj] != want[gi]);
            assign hit[gi][gj] = pend_bad | peer_bad;
         end
      end
      assign clash[gi] = |hit[gi];
   end

   assign take  = fresh & self_ok & ~clash;
   assign fault = (|(fresh & ~self_ok)) | (|(fresh & self_ok & clash));
endmodule

// File: rtl/wsb_track.sv
// Arrival register, recorded masks and completion detection.
module wsb_track #(
   parameter int unsigned LANES = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            take,
   input  logic [LANES-1:0][LANES-1:0] want,
   output logic [LANES-1:0]            waiting,
   output logic [LANES-1:0][LANES-1:0] held,
   output logic [LANES-1:0]            go
);
   logic [LANES-1:0]            arr_q;
   logic [LANES-1:0]            nxt_arr;
   logic [LANES-1:0]            done;
   logic [LANES-1:0]            go_q;
   logic [LANES-1:0][LANES-1:0] held_q;
   logic [LANES-1:0][LANES-1:0] nxt_held;

   assign nxt_arr = arr_q | take;

   for (genvar gi = 0; gi < LANES; gi++) begin : g_cover
      assign nxt_held[gi] = take[gi] ? want[gi] : held_q[gi];
      assign done[gi]     = nxt_arr[gi] & ~(|(nxt_held[gi] & ~nxt_arr));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_q  <= '0;
         held_q <= '0;
         go_q   <= '0;
      end else begin
         arr_q  <= nxt_arr & ~done;
         held_q <= nxt_held;
         go_q   <= done;
      end
   end

   assign waiting = arr_q;
   assign held    = held_q;
   assign go      = go_q;
endmodule

// File: rtl/wsb_warp_barrier.sv
module wsb_warp_barrier #(
   parameter int unsigned LANES = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       sync_req,
   input  logic [LANES*LANES-1:0] sync_mask,
   output logic [LANES-1:0]       lane_go,
   output logic                   mask_err
);
   import wsb_pkg::*;

   if (LANES < WSB_MIN_LANES || LANES > WSB_MAX_LANES) begin : g_bad_width
      $error("wsb_warp_barrier: LANES out of supported range");
   end

   logic [LANES-1:0][LANES-1:0] want_a;
   logic [LANES-1:0][LANES-1:0] held_a;
   logic [LANES-1:0]            arr_w;
   logic [LANES-1:0]            take_w;
   logic                        fault_w;
   logic                        err_q;

   assign want_a = sync_mask;

   wsb_screen #(.LANES(LANES)) u_screen (
      .req     (sync_req),
      .want    (want_a),
      .waiting (arr_w),
      .held    (held_a),
      .take    (take_w),
      .fault   (fault_w)
   );

   wsb_track #(.LANES(LANES)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take_w),
      .want    (want_a),
      .waiting (arr_w),
      .held    (held_a),
      .go      (lane_go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= fault_w;
   end

   assign mask_err = err_q;
endmodule

// File: rtl/wsb_chk.sv
module wsb_chk #(
   parameter int unsigned LANES = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [LANES-1:0]            sync_req,
   input logic [LANES*LANES-1:0]      sync_mask,
   input logic [LANES-1:0]            lane_go,
   input logic                        mask_err,
   input logic [LANES-1:0]            arrived,
   input logic [LANES-1:0][LANES-1:0] held
);
   logic [LANES-1:0] own_bit;
   for (genvar gi = 0; gi < LANES; gi++) begin : g_own
      assign own_bit[gi] = sync_mask[gi*LANES + gi];

      // R3
      go_covers_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lane_go[gi] |-> ((held[gi] & ~lane_go) == '0));
   end

   // R3
   no_stray_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_go & ~$past(arrived | sync_req)) == '0);

   // R5
   own_bit_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sync_req & ~arrived & ~own_bit)) |=> mask_err);

   // R6
   err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_err |-> $past(|sync_req));
endmodule

bind wsb_warp_barrier wsb_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_req  (sync_req),
   .sync_mask (sync_mask),
   .lane_go   (lane_go),
   .mask_err  (mask_err),
   .arrived   (arr_w),
   .held      (held_a)
);

// File: tb/tb_wsb_warp_barrier.sv
module tb_wsb_warp_barrier;
   localparam int unsigned L = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [L-1:0]     sync_req = '0;
   logic [L*L-1:0]   sync_mask = '0;
   logic [L-1:0]     lane_go;
   logic             mask_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   wsb_warp_barrier #(.LANES(L)) dut (
      .clk (clk), .rst_n (rst_n), .sync_req (sync_req),
      .sync_mask (sync_mask), .lane_go (lane_go), .mask_err (mask_err)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic put(input int lane, input logic [L-1:0] m);
      sync_req[lane] = 1'b1;
      sync_mask[lane*L +: L] = m;
   endtask

   // One cycle: requests sampled at the edge, outputs read at the next falling edge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      sync_req = '0;
   endtask

   task automatic t_reset();
      chk("R1 go after reset", 64'(lane_go), 64'h0);
      chk("R1 err after reset", 64'(mask_err), 64'h0);
      step();
      chk("R1 go idle", 64'(lane_go), 64'h0);
   endtask

   task automatic t_gather();
      for (int i = 0; i < 8; i++) begin
         put(i, 32'hFF);
         step();
         if (i < 7) chk("R3 no early go", 64'(lane_go), 64'h0);
         else       chk("R2 R3 group go", 64'(lane_go), 64'hFF);
      end
      step();
      chk("R4 pulse ends", 64'(lane_go), 64'h0);
      put(0, 32'hFF);
      step();
      chk("R4 arrivals cleared", 64'(lane_go), 64'h0);
      for (int i = 1; i < 8; i++) put(i, 32'hFF);
      step();
      chk("R4 regroup go", 64'(lane_go), 64'hFF);
      chk("R4 regroup err", 64'(mask_err), 64'h0);
   endtask

   task automatic t_single();
      put(9, 32'h200);
      step();
      chk("R10 solo go", 64'(lane_go), 64'h200);
      chk("R10 solo err", 64'(mask_err), 64'h0);
   endtask

   task automatic t_illegal();
      put(3, 32'h1);
      step();
      chk("R5 err", 64'(mask_err), 64'h1);
      chk("R5 no go", 64'(lane_go), 64'h0);
      step();
      chk("R5 err pulse", 64'(mask_err), 64'h0);
      put(0, 32'h9);
      step();
      chk("R5 lane not recorded err", 64'(mask_err), 64'h0);
      chk("R5 lane not recorded go", 64'(lane_go), 64'h0);
      put(3, 32'h9);
      step();
      chk("R5 later group go", 64'(lane_go), 64'h9);
   endtask

   task automatic t_mismatch();
      put(0, 32'h3);
      step();
      chk("R6 first err", 64'(mask_err), 64'h0);
      put(2, 32'h6);
      step();
      chk("R6 clash err", 64'(mask_err), 64'h1);
      chk("R6 clash go", 64'(lane_go), 64'h0);
      put(1, 32'h3);
      step();
      chk("R6 waiting group go", 64'(lane_go), 64'h3);
      chk("R6 waiting group err", 64'(mask_err), 64'h0);
      put(2, 32'h4);
      step();
      chk("R6 newcomer dropped", 64'(lane_go), 64'h4);
   endtask

   task automatic t_samecycle();
      put(0, 32'h3);
      put(1, 32'h7);
      step();
      chk("R7 err", 64'(mask_err), 64'h1);
      chk("R7 no go", 64'(lane_go), 64'h0);
      put(1, 32'h3);
      step();
      chk("R7 both dropped go", 64'(lane_go), 64'h0);
      chk("R7 both dropped err", 64'(mask_err), 64'h0);
      put(0, 32'h3);
      step();
      chk("R7 retry go", 64'(lane_go), 64'h3);
   endtask

   task automatic t_disjoint();
      put(0, 32'h3);
      put(4, 32'h30);
      step();
      chk("R8 none yet", 64'(lane_go), 64'h0);
      put(5, 32'h30);
      step();
      chk("R8 second group first", 64'(lane_go), 64'h30);
      chk("R8 no err", 64'(mask_err), 64'h0);
      put(1, 32'h3);
      step();
      chk("R8 first group later", 64'(lane_go), 64'h3);
   endtask

   task automatic t_dup();
      put(0, 32'h3);
      step();
      put(0, 32'h5);
      step();
      chk("R9 dup err", 64'(mask_err), 64'h0);
      chk("R9 dup go", 64'(lane_go), 64'h0);
      put(1, 32'h3);
      step();
      chk("R9 kept mask go", 64'(lane_go), 64'h3);
      chk("R9 kept mask err", 64'(mask_err), 64'h0);
   endtask

   task automatic t_full();
      for (int i = 0; i < L; i++) put(i, '1);
      step();
      chk("R11 R2 all go", 64'(lane_go), 64'hFFFF_FFFF);
      chk("R11 no err", 64'(mask_err), 64'h0);
      step();
      chk("R11 pulse ends", 64'(lane_go), 64'h0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gather();
      t_single();
      t_illegal();
      t_mismatch();
      t_samecycle();
      t_disjoint();
      t_dup();
      t_full();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule